// File: doc/BRIEF.md
# Protected Return-Address Stack

This block is a hardware stack reserved for subroutine linkage. A CALL strobe stores the return address in a private word store. That store is separate from the data stack, and no load or store can reach it. A RET strobe takes the newest entry back off. It presents the return target and the data stack pointer the caller had before the call, so the callee needs no epilogue to undo its local-variable reservation. A frame-setup strobe, issued by the callee after the call, records how many 16-bit words of locals it reserves.

Each entry is made of 16-bit words. A normal entry takes two words: the 24-bit return address and an 8-bit frame size, counted in words, held in the top byte. If a frame needs more than 254 words, the size byte carries an escape value of 255. The entry then grows by two more words that hold the full 24-bit stack pointer to restore. The store has a fixed number of words. A CALL, RET or frame-setup that cannot be carried out is dropped, and it raises a sticky error flag.

Top module: `ret_addr_stack`

## Requirements
- R1: After reset the store is empty, `ret_valid_o`, `ovf_o` and `unf_o` are 0, and `tgt_o` and `sp_o` are 0.
- R2: A RET that follows a CALL raises `ret_valid_o` for exactly one cycle, in the cycle after the RET strobe, with `tgt_o` equal to the address given at the CALL.
- R3: Entries come back in last-in first-out order across nested calls.
- R4: For a two-word entry with frame size S (0 when no frame-setup was issued), RET gives `sp_o` = `sp_i` + 2*S, taken modulo 2^24.
- R5: A frame-setup with a word count of 254 or less writes that count into the newest entry; when several are issued, the last one is the one that counts.
- R6: A frame-setup with a word count of 255 or more converts the newest entry into four words (size byte 255). The `sp_i` value given with that frame-setup is what RET returns on `sp_o`, whatever `sp_i` is at RET time.
- R7: A frame-setup with a word count of 254 or less on a four-word entry returns it to the two-word form and releases two words.
- R8: The store holds WORDS 16-bit words. A CALL with fewer than two free words, or a conversion to four words with fewer than two free words, is dropped, leaves the stored entries intact, and sets `ovf_o` until reset.
- R9: A RET or frame-setup while the store is empty is dropped, gives no `ret_valid_o`, and sets `unf_o` until reset.
- R10: When several strobes arrive in the same cycle, only one is acted on: CALL first, then RET, then frame-setup.
- R11: `tgt_o` and `sp_o` keep their values until the next accepted RET.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_i | input | 1 | CALL strobe: push the return address |
| ret_i | input | 1 | RET strobe: pop the newest entry |
| enter_i | input | 1 | Frame-setup strobe: record the frame size in the newest entry |
| ret_addr_i | input | 24 | Return address stored by CALL |
| sp_i | input | 24 | Current data stack pointer |
| frame_words_i | input | 16 | Frame size in 16-bit words for frame-setup |
| tgt_o | output | 24 | Return target from the last accepted RET |
| sp_o | output | 24 | Restored data stack pointer from the last accepted RET |
| ret_valid_o | output | 1 | One-cycle pulse after an accepted RET |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |

## Verification
A corrupted word pointer or header shows up only at the next RET. The target or restored pointer comes out wrong one cycle after the strobe, and an entry boundary in the wrong place spoils every later RET in the nest. A wrong count of used words appears later, as overflow raised too early or too late, or as underflow while entries are still stored. For that reason the stimulus keeps the store near full and converts entries between the two forms often, so pointer errors reach the ports within a few operations.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int WORD_W     = 16;
  localparam int ADDR_W     = 24;
  localparam int SIZE_W     = 8;
  localparam logic [SIZE_W-1:0] SIZE_ESC = 8'hFF;
  localparam int DIRECT_MAX = 254;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_CALL  = 2'd1,
    OP_RET   = 2'd2,
    OP_ENTER = 2'd3
  } rs_op_e;
endpackage

// File: rtl/rs_word_store.sv
module rs_word_store #(
  parameter int WORDS = 32,
  localparam int PW = $clog2(WORDS + 1),
  localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                  clk,
  input  logic [3:0]            wr_en,
  input  logic [PW-1:0]         wr_base,
  input  logic [3:0][15:0]      wr_data,
  input  logic [PW-1:0]         top_ptr,
  output logic [3:0][15:0]      rd_below
);
  logic [WORDS-1:0][15:0] mem_q;
  logic [WORDS-1:0][15:0] mem_d;
  logic [WORDS-1:0]       mem_en;

  for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
    always_comb begin
      mem_d[gi]  = mem_q[gi];
      mem_en[gi] = 1'b0;
      for (int k = 0; k < 4; k++) begin
        if (wr_en[k] && (int'(wr_base) + k == gi)) begin
          mem_d[gi]  = wr_data[k];
          mem_en[gi] = 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (mem_en[gi]) mem_q[gi] <= mem_d[gi];
    end
  end

  for (genvar gk = 0; gk < 4; gk++) begin : g_rd
    always_comb begin
      if (int'(top_ptr) > gk) rd_below[gk] = mem_q[AW'(int'(top_ptr) - gk - 1)];
      else                    rd_below[gk] = '0;
    end
  end
endmodule

// File: rtl/rs_seq.sv
module rs_seq
  import rs_pkg::*;
#(
  parameter int WORDS   = 32,
  parameter int FRAME_W = 16,
  localparam int PW = $clog2(WORDS + 1)
) (
  input  rs_op_e              op,
  input  logic [PW-1:0]       ptr,
  input  logic [3:0][15:0]    rd_below,
  input  logic [ADDR_W-1:0]   ret_addr_i,
  input  logic [ADDR_W-1:0]   sp_i,
  input  logic [FRAME_W-1:0]  frame_words_i,
  output logic [PW-1:0]       ptr_d,
  output logic [3:0]          wr_en,
  output logic [PW-1:0]       wr_base,
  output logic [3:0][15:0]    wr_data,
  output logic                ovf_set,
  output logic                unf_set,
  output logic                ret_fire,
  output logic [ADDR_W-1:0]   pop_addr,
  output logic                pop_esc,
  output logic [SIZE_W-1:0]   pop_size,
  output logic [ADDR_W-1:0]   pop_sp
);
  localparam logic [PW-1:0] WORDS_P = PW'(WORDS);
  localparam logic [PW-1:0] TWO     = PW'(2);
  localparam logic [PW-1:0] FOUR    = PW'(4);

  logic [15:0]       hdr;
  logic              empty;
  logic              top_esc;
  logic              room2;
  logic              big_frame;
  logic [PW-1:0]     entry_words;
  logic [15:0]       unused_sp_hi;

  assign hdr          = rd_below[0];
  assign empty        = (ptr == '0);
  assign top_esc      = !empty && (hdr[15:8] == SIZE_ESC);
  assign room2        = (ptr <= WORDS_P - TWO);
  assign big_frame    = (frame_words_i > FRAME_W'(DIRECT_MAX));
  assign entry_words  = top_esc ? FOUR : TWO;
  assign unused_sp_hi = rd_below[2];

  assign pop_addr = {hdr[7:0], rd_below[1]};
  assign pop_esc  = top_esc;
  assign pop_size = hdr[15:8];
  assign pop_sp   = {unused_sp_hi[7:0], rd_below[3]};

  always_comb begin
    ptr_d    = ptr;
    wr_en    = 4'b0000;
    wr_base  = ptr;
    wr_data  = '0;
    ovf_set  = 1'b0;
    unf_set  = 1'b0;
    ret_fire = 1'b0;
    unique case (op)
      OP_CALL: begin
        if (!room2) begin
          ovf_set = 1'b1;
        end else begin
          wr_en      = 4'b0011;
          wr_base    = ptr;
          wr_data[0] = ret_addr_i[15:0];
          wr_data[1] = {8'h00, ret_addr_i[23:16]};
          ptr_d      = ptr + TWO;
        end
      end
      OP_RET: begin
        if (empty) begin
          unf_set = 1'b1;
        end else begin
          ret_fire = 1'b1;
          ptr_d    = ptr - entry_words;
        end
      end
      OP_ENTER: begin
        if (empty) begin
          unf_set = 1'b1;
        end else if (!big_frame) begin
          wr_en      = 4'b0011;
          wr_base    = ptr - entry_words;
          wr_data[0] = rd_below[1];
          wr_data[1] = {frame_words_i[SIZE_W-1:0], hdr[7:0]};
          ptr_d      = top_esc ? (ptr - TWO) : ptr;
        end else if (!top_esc && !room2) begin
          ovf_set = 1'b1;
        end else begin
          wr_en      = 4'b1111;
          wr_base    = ptr - entry_words;
          wr_data[0] = sp_i[15:0];
          wr_data[1] = {8'h00, sp_i[23:16]};
          wr_data[2] = rd_below[1];
          wr_data[3] = {SIZE_ESC, hdr[7:0]};
          ptr_d      = top_esc ? ptr : (ptr + TWO);
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rs_restore.sv
module rs_restore
  import rs_pkg::*;
(
  input  logic                pop_esc,
  input  logic [SIZE_W-1:0]   pop_size,
  input  logic [ADDR_W-1:0]   pop_sp,
  input  logic [ADDR_W-1:0]   sp_i,
  output logic [ADDR_W-1:0]   sp_restored
);
  logic [ADDR_W-1:0] frame_bytes;

  assign frame_bytes = {{(ADDR_W-SIZE_W-1){1'b0}}, pop_size, 1'b0};

  always_comb begin
    if (pop_esc) sp_restored = pop_sp;
    else         sp_restored = sp_i + frame_bytes;
  end
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
  import rs_pkg::*;
#(
  parameter int WORDS   = 32,
  parameter int FRAME_W = 16,
  localparam int PW = $clog2(WORDS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                call_i,
  input  logic                ret_i,
  input  logic                enter_i,
  input  logic [23:0]         ret_addr_i,
  input  logic [23:0]         sp_i,
  input  logic [FRAME_W-1:0]  frame_words_i,
  output logic [23:0]         tgt_o,
  output logic [23:0]         sp_o,
  output logic                ret_valid_o,
  output logic                ovf_o,
  output logic                unf_o
);
  rs_op_e             op;
  logic [PW-1:0]      ptr_q, ptr_d;
  logic [3:0]         wr_en;
  logic [PW-1:0]      wr_base;
  logic [3:0][15:0]   wr_data;
  logic [3:0][15:0]   rd_below;
  logic               ovf_set, unf_set, ret_fire;
  logic [ADDR_W-1:0]  pop_addr, pop_sp, sp_restored;
  logic               pop_esc;
  logic [SIZE_W-1:0]  pop_size;

  logic [ADDR_W-1:0]  tgt_q, tgt_d, spo_q, spo_d;
  logic               vld_q, vld_d, ovf_q, ovf_d, unf_q, unf_d;

  always_comb begin
    if (call_i)       op = OP_CALL;
    else if (ret_i)   op = OP_RET;
    else if (enter_i) op = OP_ENTER;
    else              op = OP_NONE;
  end

  rs_word_store #(.WORDS(WORDS)) u_store (
    .clk      (clk),
    .wr_en    (wr_en),
    .wr_base  (wr_base),
    .wr_data  (wr_data),
    .top_ptr  (ptr_q),
    .rd_below (rd_below)
  );

  rs_seq #(.WORDS(WORDS), .FRAME_W(FRAME_W)) u_seq (
    .op            (op),
    .ptr           (ptr_q),
    .rd_below      (rd_below),
    .ret_addr_i    (ret_addr_i),
    .sp_i          (sp_i),
    .frame_words_i (frame_words_i),
    .ptr_d         (ptr_d),
    .wr_en         (wr_en),
    .wr_base       (wr_base),
    .wr_data       (wr_data),
    .ovf_set       (ovf_set),
    .unf_set       (unf_set),
    .ret_fire      (ret_fire),
    .pop_addr      (pop_addr),
    .pop_esc       (pop_esc),
    .pop_size      (pop_size),
    .pop_sp        (pop_sp)
  );

  rs_restore u_restore (
    .pop_esc     (pop_esc),
    .pop_size    (pop_size),
    .pop_sp      (pop_sp),
    .sp_i        (sp_i),
    .sp_restored (sp_restored)
  );

  always_comb begin
    tgt_d = tgt_q;
    spo_d = spo_q;
    vld_d = ret_fire;
    ovf_d = ovf_q | ovf_set;
    unf_d = unf_q | unf_set;
    if (ret_fire) begin
      tgt_d = pop_addr;
      spo_d = sp_restored;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      tgt_q <= '0;
      spo_q <= '0;
      vld_q <= 1'b0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ptr_q <= ptr_d;
      vld_q <= vld_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
      if (ret_fire) begin
        tgt_q <= tgt_d;
        spo_q <= spo_d;
      end
    end
  end

  assign tgt_o       = tgt_q;
  assign sp_o        = spo_q;
  assign ret_valid_o = vld_q;
  assign ovf_o       = ovf_q;
  assign unf_o       = unf_q;
endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
  parameter int WORDS = 32,
  localparam int PW = $clog2(WORDS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          call_i,
  input logic          ret_i,
  input logic          ret_valid_o,
  input logic          ovf_o,
  input logic          unf_o,
  input logic [PW-1:0] ptr_q
);
  // R8: the word pointer never passes the capacity
  p_ptr_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr_q) <= WORDS);

  // R8: overflow flag is sticky
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);

  // R9: underflow flag is sticky
  p_unf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    unf_o |=> unf_o);

  // R9: RET on an empty store gives no pulse and flags underflow
  p_empty_ret_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !call_i && ptr_q == '0) |=> (!ret_valid_o && unf_o));

  // R2, R10: a pulse only follows a RET strobe that was not masked by CALL
  p_valid_after_ret_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ret_valid_o) |-> $past(ret_i && !call_i));

  // R2: accepted CALL grows the store by two words
  p_call_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && int'(ptr_q) + 2 <= WORDS) |=> (int'(ptr_q) == int'($past(ptr_q)) + 2));

  // R3: an accepted RET shrinks the store
  p_ret_shrinks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !call_i && ptr_q != '0) |=> (ptr_q < $past(ptr_q)));
endmodule

bind ret_addr_stack rs_checker #(.WORDS(WORDS)) u_rs_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .call_i      (call_i),
  .ret_i       (ret_i),
  .ret_valid_o (ret_valid_o),
  .ovf_o       (ovf_o),
  .unf_o       (unf_o),
  .ptr_q       (ptr_q)
);

// File: tb/tb_ret_addr_stack.sv
module tb_ret_addr_stack;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        call_i, ret_i, enter_i;
  logic [23:0] ret_addr_i, sp_i;
  logic [15:0] frame_words_i;
  logic [23:0] tgt_o, sp_o;
  logic        ret_valid_o, ovf_o, unf_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  ret_addr_stack #(.WORDS(W), .FRAME_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i), .enter_i(enter_i),
    .ret_addr_i(ret_addr_i), .sp_i(sp_i), .frame_words_i(frame_words_i),
    .tgt_o(tgt_o), .sp_o(sp_o), .ret_valid_o(ret_valid_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model, entry level
  logic [23:0] q_ret[$];
  logic [7:0]  q_sz[$];
  logic [23:0] q_sp[$];
  int          used;
  logic [23:0] e_tgt, e_sp;
  bit          e_vld, e_ovf, e_unf;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void model_clear();
    q_ret.delete(); q_sz.delete(); q_sp.delete();
    used = 0; e_tgt = '0; e_sp = '0; e_vld = 0; e_ovf = 0; e_unf = 0;
  endfunction

  function automatic void model_step(bit c, bit r, bit e, logic [23:0] ra, logic [23:0] sp, logic [15:0] n);
    e_vld = 0;
    if (c) begin
      if (used + 2 > W) e_ovf = 1;
      else begin q_ret.push_back(ra); q_sz.push_back(8'd0); q_sp.push_back('0); used += 2; end
    end else if (r) begin
      if (q_ret.size() == 0) e_unf = 1;
      else begin
        logic [7:0] s;
        logic [23:0] p;
        e_tgt = q_ret.pop_back();
        s = q_sz.pop_back();
        p = q_sp.pop_back();
        e_vld = 1;
        if (s == 8'hFF) begin e_sp = p; used -= 4; end
        else begin e_sp = sp + {15'd0, s, 1'b0}; used -= 2; end
      end
    end else if (e) begin
      if (q_ret.size() == 0) e_unf = 1;
      else begin
        int t;
        bit esc;
        t = q_ret.size() - 1;
        esc = (q_sz[t] == 8'hFF);
        if (n <= 16'd254) begin
          q_sz[t] = n[7:0];
          if (esc) used -= 2;
        end else if (!esc && used + 2 > W) e_ovf = 1;
        else begin
          if (!esc) used += 2;
          q_sz[t] = 8'hFF;
          q_sp[t] = sp;
        end
      end
    end
  endfunction

  task automatic do_op(input string tag, input bit c, input bit r, input bit e,
                       input logic [23:0] ra, input logic [23:0] sp, input logic [15:0] n);
    @(negedge clk);
    call_i = c; ret_i = r; enter_i = e; ret_addr_i = ra; sp_i = sp; frame_words_i = n;
    model_step(c, r, e, ra, sp, n);
    @(posedge clk);
    #(CLK_PERIOD/4);
    chk(tag, "ret_valid", {31'd0, ret_valid_o}, {31'd0, e_vld});
    chk(tag, "tgt", {8'd0, tgt_o}, {8'd0, e_tgt});
    chk(tag, "sp", {8'd0, sp_o}, {8'd0, e_sp});
    chk("R8", "ovf", {31'd0, ovf_o}, {31'd0, e_ovf});
    chk("R9", "unf", {31'd0, unf_o}, {31'd0, e_unf});
    call_i = 0; ret_i = 0; enter_i = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; call_i = 0; ret_i = 0; enter_i = 0;
    ret_addr_i = '0; sp_i = '0; frame_words_i = '0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk);
    #(CLK_PERIOD/4);
    chk("R1", "reset valid", {31'd0, ret_valid_o}, 32'd0);
    chk("R1", "reset ovf", {31'd0, ovf_o}, 32'd0);
    chk("R1", "reset unf", {31'd0, unf_o}, 32'd0);
    chk("R1", "reset tgt", {8'd0, tgt_o}, 32'd0);
    chk("R1", "reset sp", {8'd0, sp_o}, 32'd0);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    do_reset();

    // R2: simple pair, hard expected values
    do_op("R2", 1, 0, 0, 24'h12_3456, 24'h00_1000, 0);
    do_op("R2", 0, 1, 0, 24'h0, 24'h00_1000, 0);
    chk("R2", "tgt direct", {8'd0, tgt_o}, 32'h0012_3456);
    chk("R4", "sp no frame", {8'd0, sp_o}, 32'h0000_1000);
    do_op("R11", 0, 0, 0, 24'h0, 24'h0, 0);
    chk("R11", "tgt held", {8'd0, tgt_o}, 32'h0012_3456);

    // R3: three-deep nest
    do_op("R3", 1, 0, 0, 24'hA0_0001, 24'h2000, 0);
    do_op("R3", 1, 0, 0, 24'hA0_0002, 24'h1F00, 0);
    do_op("R3", 1, 0, 0, 24'hA0_0003, 24'h1E00, 0);
    do_op("R3", 0, 1, 0, 0, 24'h1E00, 0);
    do_op("R3", 0, 1, 0, 0, 24'h1F00, 0);
    chk("R3", "second pop", {8'd0, tgt_o}, 32'h00A0_0002);
    do_op("R3", 0, 1, 0, 0, 24'h2000, 0);

    // R4, R5: direct frame sizes including 254 boundary
    do_op("R5", 1, 0, 0, 24'hB0_0000, 24'h8000, 0);
    do_op("R5", 0, 0, 1, 0, 24'h8000, 16'd10);
    do_op("R5", 0, 0, 1, 0, 24'h8000, 16'd254);
    do_op("R4", 0, 1, 0, 0, 24'h8000 - 24'd508, 0);
    chk("R4", "sp after 254", {8'd0, sp_o}, 32'h0000_8000);
    do_op("R4", 1, 0, 0, 24'hB0_0001, 24'hFF_FFF0, 0);
    do_op("R4", 0, 0, 1, 0, 24'hFF_FFF0, 16'd100);
    do_op("R4", 0, 1, 0, 0, 24'hFF_FFF0, 0);
    chk("R4", "sp wraps", {8'd0, sp_o}, 32'h0000_00B8);

    // R6, R7: escape form and reverting
    do_op("R6", 1, 0, 0, 24'hC0_0000, 24'h4000, 0);
    do_op("R6", 0, 0, 1, 0, 24'h4000, 16'd255);
    do_op("R6", 0, 1, 0, 0, 24'h1234, 0);
    chk("R6", "escaped sp", {8'd0, sp_o}, 32'h0000_4000);
    do_op("R7", 1, 0, 0, 24'hC0_0001, 24'h5000, 0);
    do_op("R7", 0, 0, 1, 0, 24'h5000, 16'd3000);
    do_op("R7", 0, 0, 1, 0, 24'h5000, 16'd4);
    do_op("R7", 0, 1, 0, 0, 24'h4000, 0);
    chk("R7", "reverted sp", {8'd0, sp_o}, 32'h0000_4008);

    // R10: priority
    do_op("R10", 1, 0, 0, 24'hD0_0000, 24'h100, 0);
    do_op("R10", 1, 1, 1, 24'hD0_0001, 24'h100, 16'd9);
    do_op("R10", 0, 1, 1, 0, 24'h100, 16'd9);
    chk("R10", "call won", {8'd0, tgt_o}, 32'h00D0_0001);
    do_op("R10", 0, 1, 0, 0, 24'h100, 0);

    // R8: fill, overflow, intact contents
    for (int i = 0; i < W/2; i++) do_op("R8", 1, 0, 0, 24'hE0_0000 + 24'(i), 24'h300, 0);
    do_op("R8", 1, 0, 0, 24'hEE_EEEE, 24'h300, 0);
    do_op("R8", 0, 0, 1, 0, 24'h300, 16'd400);
    chk("R8", "ovf raised", {31'd0, ovf_o}, 32'd1);
    do_op("R8", 0, 1, 0, 0, 24'h300, 0);
    chk("R8", "top intact", {8'd0, tgt_o}, 32'h00E0_0007);
    chk("R8", "no escape", {8'd0, sp_o}, 32'h0000_0300);
    for (int i = 0; i < W/2 - 1; i++) do_op("R3", 0, 1, 0, 0, 24'h300, 0);

    // R9: underflow
    do_op("R9", 0, 1, 0, 0, 24'h0, 0);
    do_op("R9", 0, 0, 1, 0, 24'h0, 16'd5);
    chk("R9", "unf raised", {31'd0, unf_o}, 32'd1);

    // random phases
    for (int ph = 0; ph < 6; ph++) begin
      do_reset();
      for (int i = 0; i < 2000; i++) begin
        int sel;
        bit c, r, e;
        logic [15:0] n;
        sel = $urandom_range(0, 99);
        c = (sel < 35);
        r = (sel >= 35 && sel < 65) || (sel % 17 == 0);
        e = (sel >= 65) || (sel % 13 == 0);
        case ($urandom_range(0, 5))
          0: n = 16'd254;
          1: n = 16'd255;
          2: n = 16'($urandom_range(256, 5000));
          default: n = 16'($urandom_range(0, 253));
        endcase
        do_op(r ? "R4" : (e ? "R5" : "R2"), c, r, e,
              24'($urandom), 24'($urandom), n);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule